// File: doc/BRIEF.md
# Precise Exception Capture Unit

This block sits at the commit stage of an in-order pipeline that retires up to `NumLanes` instructions per cycle. Lane 0 holds the oldest instruction. Each lane presents a valid flag, its program counter, an exception request, a 5-bit reason code and a flag that marks an instruction sitting in a branch delay slot.

When any lane raises an exception, the block finds the oldest faulting lane. Every older lane keeps its writeback and store enable. The faulting lane and every younger lane are killed in the same cycle, and a trap redirect sends fetch to a fixed handler address. On the next clock edge the block captures two registers:

- The exception PC. This is the faulting instruction's address, or the address of the preceding branch when the fault sits in a delay slot.
- The cause register. This holds the reason code and a delay-slot flag.

At the same edge the block sets an exception-level flag.

A return-from-exception request sends fetch back to the saved exception PC and clears the exception-level flag.

Top module: `preciseExcUnit`

## Requirements
- R1: After reset, `epcOut` and `causeOut` are zero, `excLevel` is 0, and no redirect is issued while no exception or return request is present.
- R2: When the oldest faulting lane is not in a delay slot, `epcOut` holds that lane's PC from the clock edge that ends the faulting cycle.
- R3: At the same edge, `causeOut[6:2]` holds the faulting lane's code. All other bits are zero, except bit 31 as given by R6.
- R4: Every valid lane older than the oldest faulting lane keeps `commitEn` high in the faulting cycle.
- R5: The oldest faulting lane and every younger lane have `commitEn` low in the faulting cycle. The same holds for any lane whose valid flag is low.
- R6: When the oldest faulting lane has its delay-slot flag set, `epcOut` becomes its PC minus 4 and `causeOut[31]` becomes 1. Otherwise `causeOut[31]` becomes 0.
- R7: When several lanes fault in one cycle, only the lowest-numbered faulting lane (the oldest) is recorded.
- R8: In a faulting cycle, `trapTaken` and `redirectValid` are 1 and `redirectPc` equals `TrapVector`. `excLevel` is 1 from the next edge.
- R9: A return request with no fault in the same cycle drives `redirectValid`=1, `trapTaken`=0 and `redirectPc`=`epcOut` in that cycle. `excLevel` is 0 from the next edge, and `epcOut` and `causeOut` are unchanged.
- R10: When a fault and a return request arrive in the same cycle, the trap wins: the fault is recorded per R2, R3, R6 and R7, `excLevel` becomes 1, and `redirectPc` is `TrapVector`.
- R11: In a cycle with no fault, `epcOut` and `causeOut` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| commitValid | input | NumLanes | Lane holds a committing instruction |
| commitPc | input | NumLanes*XLEN | Lane PCs, lane i at bits [i*XLEN +: XLEN] |
| commitExc | input | NumLanes | Lane requests an exception |
| commitCode | input | NumLanes*5 | Lane reason codes, lane i at bits [i*5 +: 5] |
| commitInSlot | input | NumLanes | Lane instruction is in a branch delay slot |
| eretReq | input | 1 | Return-from-exception request |
| commitEn | output | NumLanes | Writeback and store enable per lane |
| trapTaken | output | 1 | Trap pulse, also flushes younger in-flight work |
| redirectValid | output | 1 | Fetch redirect this cycle |
| redirectPc | output | XLEN | Fetch redirect target |
| epcOut | output | XLEN | Saved exception PC |
| causeOut | output | 32 | Cause register: code at [6:2], delay-slot flag at 31 |
| excLevel | output | 1 | Exception-level flag |

## Verification
A wrong priority pick in the control shows up at once. It drops or keeps the wrong `commitEn` bit in the faulting cycle itself. One edge later it also leaves the younger lane's PC and code in `epcOut` and `causeOut`.

A datapath fault shows one edge after the trap. Examples are a missing minus-4 for a delay slot, a misplaced code field, or an exception-level flag that is not set or not cleared. It persists until the next trap or return request. A wrong return target is visible in the same cycle on `redirectPc`.

// File: rtl/preciseExcPkg.sv
package preciseExcPkg;
  localparam int CodeW   = 5;
  localparam int CodeLsb = 2;
  localparam int SlotBit = 31;
  localparam int CauseW  = 32;

  typedef struct packed {
    logic loadTrap;
    logic restore;
    logic inSlot;
  } excStrobes_t;
endpackage

// File: rtl/excCtrl.sv
module excCtrl
  import preciseExcPkg::*;
#(
  parameter int NumLanes = 2,
  localparam int IdxW = (NumLanes > 1) ? $clog2(NumLanes) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumLanes-1:0] laneValid,
  input  logic [NumLanes-1:0] laneExc,
  input  logic [NumLanes-1:0] laneSlot,
  input  logic                eretReq,
  output logic [NumLanes-1:0] commitEn,
  output logic [IdxW-1:0]     faultIdx,
  output excStrobes_t         strobes
);
  logic anyFault;
  logic [NumLanes-1:0] faultVec;

  assign faultVec = laneValid & laneExc;

  // Oldest lane wins: scan from youngest down so the lowest index is last.
  always_comb begin
    anyFault = 1'b0;
    faultIdx = '0;
    for (int i = NumLanes - 1; i >= 0; i--) begin
      if (faultVec[i]) begin
        anyFault = 1'b1;
        faultIdx = IdxW'(i);
      end
    end
  end

  for (genvar g = 0; g < NumLanes; g++) begin : gLane
    assign commitEn[g] = laneValid[g] && !(anyFault && (IdxW'(g) >= faultIdx));

    p_kill_fault_r5: assert property (@(posedge clk) disable iff (!rstN)
      faultVec[g] |-> !commitEn[g]);
  end

  always_comb begin
    strobes.loadTrap = anyFault;
    strobes.restore  = eretReq && !anyFault;
    strobes.inSlot   = laneSlot[faultIdx];
  end

  p_oldest_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (laneValid[0] && !laneExc[0]) |-> commitEn[0]);
  p_one_action_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadTrap, strobes.restore}));
endmodule

// File: rtl/excDatapath.sv
module excDatapath
  import preciseExcPkg::*;
#(
  parameter int NumLanes = 2,
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] TrapVector = 32'h0000_0180,
  localparam int IdxW = (NumLanes > 1) ? $clog2(NumLanes) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NumLanes*XLEN-1:0]   lanePc,
  input  logic [NumLanes*CodeW-1:0]  laneCode,
  input  logic [IdxW-1:0]            faultIdx,
  input  excStrobes_t                strobes,
  output logic                       trapTaken,
  output logic                       redirectValid,
  output logic [XLEN-1:0]            redirectPc,
  output logic [XLEN-1:0]            epcOut,
  output logic [CauseW-1:0]          causeOut,
  output logic                       excLevel
);
  logic [XLEN-1:0]   selPc;
  logic [CodeW-1:0]  selCode;
  logic [XLEN-1:0]   epcNext;
  logic [CauseW-1:0] causeNext;

  assign selPc   = lanePc[faultIdx*XLEN +: XLEN];
  assign selCode = laneCode[faultIdx*CodeW +: CodeW];
  assign epcNext = strobes.inSlot ? (selPc - XLEN'(4)) : selPc;

  always_comb begin
    causeNext = '0;
    causeNext[SlotBit] = strobes.inSlot;
    causeNext[CodeLsb +: CodeW] = selCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epcOut   <= '0;
      causeOut <= '0;
      excLevel <= 1'b0;
    end else if (strobes.loadTrap) begin
      epcOut   <= epcNext;
      causeOut <= causeNext;
      excLevel <= 1'b1;
    end else if (strobes.restore) begin
      excLevel <= 1'b0;
    end
  end

  assign trapTaken     = strobes.loadTrap;
  assign redirectValid = strobes.loadTrap | strobes.restore;
  assign redirectPc    = strobes.loadTrap ? TrapVector : epcOut;

  p_slot_epc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadTrap && strobes.inSlot) |=> (epcOut == $past(selPc) - XLEN'(4) && causeOut[SlotBit]));
  p_level_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadTrap |=> excLevel);
  p_level_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restore |=> (!excLevel && $stable(epcOut)));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadTrap |=> ($stable(epcOut) && $stable(causeOut)));
  p_cause_clean_r3: assert property (@(posedge clk) disable iff (!rstN)
    (causeOut[SlotBit-1:CodeLsb+CodeW] == '0) && (causeOut[CodeLsb-1:0] == '0));
endmodule

// File: rtl/preciseExcUnit.sv
module preciseExcUnit
  import preciseExcPkg::*;
#(
  parameter int NumLanes = 2,
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] TrapVector = 32'h0000_0180
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumLanes-1:0]       commitValid,
  input  logic [NumLanes*XLEN-1:0]  commitPc,
  input  logic [NumLanes-1:0]       commitExc,
  input  logic [NumLanes*5-1:0]     commitCode,
  input  logic [NumLanes-1:0]       commitInSlot,
  input  logic                      eretReq,
  output logic [NumLanes-1:0]       commitEn,
  output logic                      trapTaken,
  output logic                      redirectValid,
  output logic [XLEN-1:0]           redirectPc,
  output logic [XLEN-1:0]           epcOut,
  output logic [31:0]               causeOut,
  output logic                      excLevel
);
  localparam int IdxW = (NumLanes > 1) ? $clog2(NumLanes) : 1;

  logic [IdxW-1:0] faultIdx;
  excStrobes_t     strobes;

  excCtrl #(.NumLanes(NumLanes)) uCtrl (
    .clk(clk), .rstN(rstN),
    .laneValid(commitValid), .laneExc(commitExc), .laneSlot(commitInSlot),
    .eretReq(eretReq), .commitEn(commitEn), .faultIdx(faultIdx), .strobes(strobes)
  );

  excDatapath #(.NumLanes(NumLanes), .XLEN(XLEN), .TrapVector(TrapVector)) uPath (
    .clk(clk), .rstN(rstN),
    .lanePc(commitPc), .laneCode(commitCode), .faultIdx(faultIdx), .strobes(strobes),
    .trapTaken(trapTaken), .redirectValid(redirectValid), .redirectPc(redirectPc),
    .epcOut(epcOut), .causeOut(causeOut), .excLevel(excLevel)
  );
endmodule

// File: tb/tb_preciseExcUnit.sv
`timescale 1ns/1ps
module tb_preciseExcUnit;
  localparam logic [31:0] Vec = 32'h0000_0180;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]  commitValid = '0, commitExc = '0, commitInSlot = '0;
  logic [63:0] commitPc = '0;
  logic [9:0]  commitCode = '0;
  logic        eretReq = 1'b0;
  logic [1:0]  commitEn;
  logic        trapTaken, redirectValid, excLevel;
  logic [31:0] redirectPc, epcOut, causeOut;

  int checks = 0, fails = 0;
  logic [31:0] mEpc = '0, mCause = '0;
  logic        mLvl = 1'b0;

  always #2.5 clk = ~clk;

  preciseExcUnit dut (
    .clk(clk), .rstN(rstN), .commitValid(commitValid), .commitPc(commitPc),
    .commitExc(commitExc), .commitCode(commitCode), .commitInSlot(commitInSlot),
    .eretReq(eretReq), .commitEn(commitEn), .trapTaken(trapTaken),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .epcOut(epcOut),
    .causeOut(causeOut), .excLevel(excLevel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int oldestFault(input logic [1:0] v, input logic [1:0] e);
    if (v[0] && e[0]) return 0;
    if (v[1] && e[1]) return 1;
    return -1;
  endfunction

  function automatic logic [1:0] expEn(input logic [1:0] v, input int f);
    logic [1:0] r;
    for (int i = 0; i < 2; i++) r[i] = v[i] && (f < 0 || i < f);
    return r;
  endfunction

  task automatic step(input logic [1:0] v, input logic [1:0] e, input logic [31:0] p0,
                      input logic [31:0] p1, input logic [4:0] c0, input logic [4:0] c1,
                      input logic [1:0] s, input logic er);
    int f;
    logic [31:0] pcs [2];
    logic [4:0]  cds [2];
    string tag;
    @(negedge clk);
    commitValid = v; commitExc = e; commitInSlot = s; eretReq = er;
    commitPc = {p1, p0}; commitCode = {c1, c0};
    pcs[0] = p0; pcs[1] = p1; cds[0] = c0; cds[1] = c1;
    #1;
    f = oldestFault(v, e);
    check((f == 0) ? "R5" : "R4", {30'd0, commitEn}, {30'd0, expEn(v, f)});
    if (f >= 0) begin
      check(er ? "R10" : "R8", {trapTaken, redirectValid}, 32'd3);
      check(er ? "R10" : "R8", redirectPc, Vec);
    end else if (er) begin
      check("R9", {trapTaken, redirectValid}, 32'd1);
      check("R9", redirectPc, mEpc);
    end else begin
      check("R1", {trapTaken, redirectValid}, 32'd0);
    end
    @(posedge clk);
    if (f >= 0) begin
      mEpc = s[f] ? pcs[f] - 32'd4 : pcs[f];
      mCause = '0;
      mCause[31] = s[f];
      mCause[6:2] = cds[f];
      mLvl = 1'b1;
    end else if (er) begin
      mLvl = 1'b0;
    end
    #1;
    if (f < 0) tag = er ? "R9" : "R11";
    else if (v[0] && e[0] && v[1] && e[1]) tag = "R7";
    else if (s[f]) tag = "R6";
    else tag = "R2";
    check(tag, epcOut, mEpc);
    check((f >= 0) ? "R3" : tag, causeOut, mCause);
    check((f >= 0) ? (er ? "R10" : "R8") : tag, {31'd0, excLevel}, {31'd0, mLvl});
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    check("R1", epcOut, 32'd0);
    check("R1", causeOut, 32'd0);
    check("R1", {31'd0, excLevel}, 32'd0);
    // Directed corners
    step(2'b11, 2'b00, 32'h100, 32'h104, 5'd0, 5'd0, 2'b00, 1'b0); // R11 quiet commit
    step(2'b11, 2'b01, 32'h200, 32'h204, 5'd12, 5'd3, 2'b00, 1'b0); // R2 lane0 fault
    step(2'b11, 2'b10, 32'h300, 32'h304, 5'd4, 5'd10, 2'b10, 1'b0); // R6 slot in lane1
    step(2'b00, 2'b00, 32'h0, 32'h0, 5'd0, 5'd0, 2'b00, 1'b1);      // R9 return
    step(2'b11, 2'b11, 32'h400, 32'h404, 5'd8, 5'd9, 2'b10, 1'b0);  // R7 both fault
    step(2'b10, 2'b11, 32'h500, 32'h504, 5'd1, 5'd31, 2'b00, 1'b1); // R10 lane0 invalid
    step(2'b01, 2'b01, 32'h8, 32'h0, 5'd7, 5'd0, 2'b01, 1'b0);      // R6 slot lane0
    for (int n = 0; n < 3000; n++) begin
      step(2'($urandom), 2'(($urandom % 4 == 0) ? $urandom : 0),
           {$urandom} & 32'hFFFF_FFFC, {$urandom} & 32'hFFFF_FFFC,
           5'($urandom), 5'($urandom), 2'($urandom), ($urandom % 6 == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule